// File: doc/BRIEF.md
# PWM Fault Input Conditioner

This block sits in front of a PWM output stage and turns eight raw fault lines into eight qualified fault flags. Each line is first synchronized to the block clock. It is then optionally passed through a three-sample agreement filter and compared against a per-line active level. The last stage is a small per-line state machine that decides how long the flag stays raised. The PWM counters and output override logic only consume the flags. The protection bits are driven from outside.

Software sets the block up through one 32-bit mode register. Writes to it are dropped while either protection input is high. A write-one-to-clear strobe releases flags that are held by the latching activation mode. A status output carries the eight current flags.

Each line runs a four-state machine. The states are `ST_IDLE` (no fault), `ST_LIVE` (condition present, no clear seen), `ST_ARMED` (condition present, clear already recorded) and `ST_STUCK` (condition gone, clear still awaited). The flag is high in every state except `ST_IDLE`.

In held mode the transitions are:
- `ST_IDLE` goes to `ST_LIVE` on condition.
- `ST_LIVE` goes to `ST_ARMED` on clear with the condition present, to `ST_IDLE` on clear with no condition, and to `ST_STUCK` on no condition.
- `ST_ARMED` goes to `ST_IDLE` when the condition drops.
- `ST_STUCK` goes to `ST_IDLE` on clear, to `ST_ARMED` on clear with the condition back, and to `ST_LIVE` when the condition returns.

In follow mode the next state is `ST_LIVE` when the condition is present and `ST_IDLE` otherwise.

Top module: `pwm_fault_cond`

## Requirements
- R1: While reset is asserted, and right after it, the mode register reads zero and all eight flags are low.
- R2: An unprotected write stores bits 23:16 (filter enable), 15:8 (activation mode) and 7:0 (active level), with bit y of each field controlling line y. Bits 31:24 always read zero, and the stored value is readable on the next cycle.
- R3: A write is ignored while the software protect input or the hardware protect input is high. Such a write leaves the register and the flags unchanged.
- R4: With active-level bit y at 0, line y is in fault when its input is low. With the bit at 1, it is in fault when its input is high.
- R5: With mode bit y at 0, flag y follows the condition. An unfiltered input change is visible on the flag after exactly three rising clock edges.
- R6: With mode bit y at 1, flag y stays high after the condition has gone, until a clear strobe with bit y set is accepted. The flag then drops one edge later.
- R7: A clear for line y accepted while its condition is still present is remembered. The held flag then drops on the first state update that sees no condition, with no second clear.
- R8: With filter bit y at 1, an input level reaches the flag only after it has been stable for three consecutive synchronized samples, which is six edges in total. Pulses of two clocks or shorter never raise the flag.
- R9: A clear strobe affects only the lines whose bits are set. A clear with bit y at 0 leaves a held flag y high.
- R10: The lines are independent, so a mix of levels and active-level settings gives each flag its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 8 | Raw fault lines, asynchronous |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wdata | input | 32 | Mode register write data |
| wp_sw | input | 1 | Software write-protect status |
| wp_hw | input | 1 | Hardware write-protect status |
| clr_wr_en | input | 1 | Fault clear strobe |
| clr_wdata | input | 8 | Write-one-to-clear mask, bit y for line y |
| cfg_rdata | output | 32 | Mode register read value |
| fault_active | output | 8 | Qualified fault flags |

## Verification
The properties assume that `rst_n` is low from time zero for at least one edge. They also assume that the write, clear and protect inputs change only away from the rising edge, so the value sampled at an edge is the value intended for that cycle. The bench drives every input on the falling edge and holds reset low over several edges before releasing it. It also keeps the fault lines at the inactive level for the active-level setting loaded, except inside the windows where a test raises a fault on purpose. Glitch pulses are timed in whole clock cycles so the sampled values are always determinate.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;
    localparam int FLT_LINES    = 8;
    localparam int FLT_REG_W    = 32;
    localparam int FLT_SYNC_LEN = 2;
    localparam int FLT_AGREE    = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LIVE  = 2'd1,
        ST_ARMED = 2'd2,
        ST_STUCK = 2'd3
    } hold_state_t;
endpackage

// File: rtl/pwm_fault_sync.sv
module pwm_fault_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_fault_filter.sv
module pwm_fault_filter #(
    parameter int LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;

    logic [CW-1:0] run;
    logic          level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= 1'b1;
            run   <= '0;
        end else if (d != level) begin
            if (run == CW'(LEN - 1)) begin
                level <= d;
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end

    assign q = level;
endmodule

// File: rtl/pwm_fault_hold.sv
module pwm_fault_hold
    import pwm_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic held_mode,
    input  logic cond,
    input  logic clr,
    output logic flag
);
    hold_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!held_mode) begin
            st_d = cond ? ST_LIVE : ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = cond ? ST_LIVE : ST_IDLE;
                ST_LIVE: begin
                    if (cond) st_d = clr ? ST_ARMED : ST_LIVE;
                    else      st_d = clr ? ST_IDLE  : ST_STUCK;
                end
                ST_ARMED: st_d = cond ? ST_ARMED : ST_IDLE;
                ST_STUCK: begin
                    if (cond) st_d = clr ? ST_ARMED : ST_LIVE;
                    else      st_d = clr ? ST_IDLE  : ST_STUCK;
                end
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        flag = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
    import pwm_fault_pkg::*;
#(
    parameter int LINES = FLT_LINES,
    parameter int REG_W = FLT_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] fault_in,
    input  logic             cfg_wr_en,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic             wp_sw,
    input  logic             wp_hw,
    input  logic             clr_wr_en,
    input  logic [LINES-1:0] clr_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic [LINES-1:0] fault_active
);
    localparam int POL_LSB  = 0;
    localparam int MODE_LSB = LINES;
    localparam int FILT_LSB = 2 * LINES;
    localparam int USED_W   = 3 * LINES;

    logic [USED_W-1:0] cfg_q;
    logic [LINES-1:0]  pol, held, filt_en;
    logic [LINES-1:0]  sync_lvl, filt_lvl, cond;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              cfg_q <= '0;
        else if (cfg_wr_en && !wp_sw && !wp_hw)  cfg_q <= cfg_wdata[USED_W-1:0];
    end

    assign pol       = cfg_q[POL_LSB  +: LINES];
    assign held      = cfg_q[MODE_LSB +: LINES];
    assign filt_en   = cfg_q[FILT_LSB +: LINES];
    assign cfg_rdata = {{(REG_W-USED_W){1'b0}}, cfg_q};

    pwm_fault_sync #(.W(LINES), .STAGES(FLT_SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fault_in),
        .q     (sync_lvl)
    );

    for (genvar y = 0; y < LINES; y++) begin : g_line
        pwm_fault_filter #(.LEN(FLT_AGREE)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (sync_lvl[y]),
            .q     (filt_lvl[y])
        );

        assign cond[y] = ((filt_en[y] ? filt_lvl[y] : sync_lvl[y]) == pol[y]);

        pwm_fault_hold u_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .held_mode (held[y]),
            .cond      (cond[y]),
            .clr       (clr_wr_en && clr_wdata[y]),
            .flag      (fault_active[y])
        );
    end
endmodule

// File: rtl/pwm_fault_cond_chk.sv
module pwm_fault_cond_chk #(
    parameter int LINES = 8,
    parameter int REG_W = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_wr_en,
    input logic [REG_W-1:0]     cfg_wdata,
    input logic                 wp_sw,
    input logic                 wp_hw,
    input logic                 clr_wr_en,
    input logic [LINES-1:0]     clr_wdata,
    input logic [REG_W-1:0]     cfg_rdata,
    input logic [LINES-1:0]     fault_active,
    input logic [LINES-1:0]     cond,
    input logic [3*LINES-1:0]   cfg_q
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (fault_active == '0 && cfg_rdata == '0));

    a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && !wp_sw && !wp_hw) |=>
            cfg_rdata[3*LINES-1:0] == $past(cfg_wdata[3*LINES-1:0]));

    a_r2_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[REG_W-1:3*LINES] == '0);

    a_r3_protect: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && (wp_sw || wp_hw)) |=> $stable(cfg_rdata));

    for (genvar y = 0; y < LINES; y++) begin : g_chk
        a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_q[LINES+y] |=> fault_active[y] == $past(cond[y]));

        a_r6_cond_raises: assert property (@(posedge clk) disable iff (!rst_n)
            cond[y] |=> fault_active[y]);

        a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[LINES+y] && fault_active[y] && !cond[y] && clr_wr_en && clr_wdata[y])
                |=> !fault_active[y]);
    end
endmodule

bind pwm_fault_cond pwm_fault_cond_chk #(.LINES(LINES), .REG_W(REG_W)) u_chk (.*);

// File: tb/pwm_fault_cond_test.sv
module pwm_fault_cond_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fault_in = 8'hFF;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        wp_sw = 1'b0;
    logic        wp_hw = 1'b0;
    logic        clr_wr_en = 1'b0;
    logic [7:0]  clr_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  fault_active;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_fault_cond uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault_in     (fault_in),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wdata    (cfg_wdata),
        .wp_sw        (wp_sw),
        .wp_hw        (wp_hw),
        .clr_wr_en    (clr_wr_en),
        .clr_wdata    (clr_wdata),
        .cfg_rdata    (cfg_rdata),
        .fault_active (fault_active)
    );

    // {active level, input pattern, expected flags}, follow mode, unfiltered
    localparam logic [23:0] VEC [4] = '{
        {8'h00, 8'hFF, 8'h00},
        {8'h00, 8'h0F, 8'hF0},
        {8'hFF, 8'h0F, 8'h0F},
        {8'hA5, 8'h3C, 8'h66}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v);
        cfg_wr_en = 1'b1;
        cfg_wdata = v;
        tick(1);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clr_pulse(input logic [7:0] m);
        clr_wr_en = 1'b1;
        clr_wdata = m;
        tick(1);
        clr_wr_en = 1'b0;
        clr_wdata = '0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            report();
        end
    end

    initial begin
        int seen;
        tick(4);
        check("R1 flags in reset", {24'h0, fault_active}, 32'h0);
        check("R1 register in reset", cfg_rdata, 32'h0);
        rst_n = 1'b1;
        tick(4);
        check("R1 flags after reset", {24'h0, fault_active}, 32'h0);

        // R2: field storage and upper byte reads zero
        cfg_write(32'hFF12_0000);
        check("R2 readback", cfg_rdata, 32'h0012_0000);
        cfg_write(32'h0000_0000);
        check("R2 readback zero", cfg_rdata, 32'h0);

        // R3: protected writes ignored
        wp_sw = 1'b1;
        cfg_write(32'h0000_00FF);
        check("R3 sw protect register", cfg_rdata, 32'h0);
        wp_sw = 1'b0; wp_hw = 1'b1;
        cfg_write(32'h0000_00FF);
        check("R3 hw protect register", cfg_rdata, 32'h0);
        wp_hw = 1'b0;
        tick(4);
        check("R3 protect flags", {24'h0, fault_active}, 32'h0);

        // R4, R10: vector table
        foreach (VEC[i]) begin
            cfg_write({16'h0, 8'h00, VEC[i][23:16]});
            fault_in = VEC[i][15:8];
            tick(5);
            check("R4 R10 table", {24'h0, fault_active}, {24'h0, VEC[i][7:0]});
        end
        cfg_write(32'h0);
        fault_in = 8'hFF;
        tick(5);

        // R5: three-edge latency, unfiltered follow mode
        fault_in[0] = 1'b0;
        tick(2);
        check("R5 before third edge", {31'h0, fault_active[0]}, 32'h0);
        tick(1);
        check("R5 at third edge", {31'h0, fault_active[0]}, 32'h1);
        fault_in[0] = 1'b1;
        tick(3);
        check("R5 drop follows", {31'h0, fault_active[0]}, 32'h0);

        // R6, R9: held mode on line 1
        cfg_write(32'h0000_0200);
        fault_in[1] = 1'b0;
        tick(3);
        check("R6 raised", {31'h0, fault_active[1]}, 32'h1);
        fault_in[1] = 1'b1;
        tick(6);
        check("R6 held after condition gone", {31'h0, fault_active[1]}, 32'h1);
        clr_pulse(8'h04);
        tick(1);
        check("R9 other-bit clear keeps flag", {31'h0, fault_active[1]}, 32'h1);
        clr_pulse(8'h02);
        check("R6 released by clear", {31'h0, fault_active[1]}, 32'h0);

        // R7: clear recorded while condition present
        fault_in[1] = 1'b0;
        tick(3);
        clr_pulse(8'h02);
        tick(3);
        check("R7 still raised while present", {31'h0, fault_active[1]}, 32'h1);
        fault_in[1] = 1'b1;
        tick(2);
        check("R7 before release edge", {31'h0, fault_active[1]}, 32'h1);
        tick(1);
        check("R7 released without second clear", {31'h0, fault_active[1]}, 32'h0);

        // R8: filter on line 3, follow mode
        cfg_write(32'h0008_0000);
        tick(4);
        fault_in[3] = 1'b0;
        tick(2);
        fault_in[3] = 1'b1;
        seen = 0;
        for (int k = 0; k < 10; k++) begin
            tick(1);
            if (fault_active[3]) seen++;
        end
        check("R8 short pulse rejected", seen, 0);
        fault_in[3] = 1'b0;
        tick(5);
        check("R8 before sixth edge", {31'h0, fault_active[3]}, 32'h0);
        tick(1);
        check("R8 at sixth edge", {31'h0, fault_active[3]}, 32'h1);
        fault_in[3] = 1'b1;
        tick(5);
        check("R8 release before sixth edge", {31'h0, fault_active[3]}, 32'h1);
        tick(1);
        check("R8 release at sixth edge", {31'h0, fault_active[3]}, 32'h0);

        report();
    end
endmodule